// File: doc/BRIEF.md
# Two-Entry Program Patch Redirect Unit

This block lets software replace faulty code in mask ROM of an 8-bit microcontroller with a 16-bit address space. Software programs up to two instruction addresses into byte-wide registers on a simple memory-mapped bus and enables each entry on its own. The block watches the address of every opcode fetch. When a fetch hits an enabled entry, it raises a redirect in the same cycle and supplies the fixed RAM address of that entry's patch routine. The instruction sequencer then jumps there instead of executing the ROM byte. The patch routine ends with its own jump back into ROM, and that jump is not part of this block.

The compare runs combinationally against registered values, so the sequencer sees the redirect with no added latency. A single expansion-ROM select input exempts the 0x1000–0x1FFF fetch window from matching while it is set.

Top module: `patch_redirect`

## Requirements
- R1: After reset every compare address reads 0x00 in both bytes, the control register reads 0x00, and no redirect occurs, even for a fetch at 0x0000.
- R2: Bus address 0x020C holds the high byte and 0x020D the low byte of entry 1's compare address. 0x020E and 0x020F hold the same for entry 2. A read of each returns the last byte written to it.
- R3: The control register sits at 0x0210. Bit 0 enables entry 1 and bit 1 enables entry 2. Bits 2 and 3 store whatever is written to them. Bits 7:4 ignore writes and always read 0.
- R4: A read of any unmapped bus address returns 0x00.
- R5: When the opcode-fetch strobe is high, the fetch address equals an enabled entry's address, and no exemption applies, `redirect` is 1 in that same cycle. `redirect_target` is then 0x02C0 for entry 1 or 0x02E0 for entry 2. While `redirect` is 0, `redirect_target` is 0x0000.
- R6: A fetch address that matches while the opcode-fetch strobe is low, as on an operand fetch, never causes a redirect.
- R7: An entry whose enable bit is 0 never causes a redirect.
- R8: While `ext_rom_sel` is 1, fetch addresses 0x1000 through 0x1FFF never redirect. Addresses outside that window still redirect. While `ext_rom_sel` is 0, the window is not exempt.
- R9: If both entries are enabled and both match, entry 1 wins and the target is 0x02C0.
- R10: A register write changes the compare only from the following cycle onward. A fetch in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_rdata | output | 8 | Register read data (0 when not reading) |
| fetch_addr | input | 16 | Address of the current program fetch |
| fetch_op | input | 1 | High when the current fetch is an opcode fetch |
| ext_rom_sel | input | 1 | Expansion ROM selected |
| redirect | output | 1 | Jump to patch routine this cycle |
| redirect_target | output | 16 | RAM address of the patch routine |

## Verification
The bench puts both entries on the same address. A design with the priority inverted would jump to 0x02E0 instead of 0x02C0. It probes the exempt window at both edges, 0x1000 and 0x1FFF, and just outside at 0x0FFF and 0x2000, with the expansion select set and cleared. An off-by-one window would either suppress a legal patch or redirect inside expansion ROM. It writes a compare byte and fetches in the same cycle, which catches a bypass path that would act on the new value too early. It also repeats a matching fetch with the opcode strobe low, which a design that ignored the strobe would wrongly redirect. Finally, it writes all ones to the control register, which exposes upper bits that were stored or lower reserved bits that were dropped.

// File: rtl/patch_redirect.sv
module patch_redirect #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_BASE = 16'h020C,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h0210,
  parameter logic [AW-1:0] VEC_A = 16'h02C0,
  parameter logic [AW-1:0] VEC_B = 16'h02E0,
  parameter logic [AW-1:0] EXEMPT_LO = 16'h1000,
  parameter logic [AW-1:0] EXEMPT_HI = 16'h1FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_op,
  input  logic          ext_rom_sel,
  output logic          redirect,
  output logic [AW-1:0] redirect_target
);
  localparam int NE = 2;
  localparam int CW = 4;

  logic [AW-1:0] patch_a [NE];
  logic [CW-1:0] ctrl_q;
  logic [NE-1:0] hit;
  logic [NE-1:0] rd_hi, rd_lo;
  logic          exempt;

  assign exempt = ext_rom_sel && fetch_addr >= EXEMPT_LO && fetch_addr <= EXEMPT_HI;

  for (genvar g = 0; g < NE; g++) begin : g_ent
    localparam logic [AW-1:0] HI_A = REG_BASE + AW'(2 * g);
    localparam logic [AW-1:0] LO_A = HI_A + AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        patch_a[g] <= '0;
      end else if (bus_we) begin
        if (bus_addr == HI_A) patch_a[g][AW-1:DW] <= bus_wdata;
        if (bus_addr == LO_A) patch_a[g][DW-1:0]  <= bus_wdata;
      end
    end

    assign rd_hi[g] = bus_addr == HI_A;
    assign rd_lo[g] = bus_addr == LO_A;
    assign hit[g]   = fetch_op && ctrl_q[g] && !exempt && fetch_addr == patch_a[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_we && bus_addr == CTRL_ADDR) ctrl_q <= bus_wdata[CW-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      for (int i = 0; i < NE; i++) begin
        if (rd_hi[i]) bus_rdata = patch_a[i][AW-1:DW];
        if (rd_lo[i]) bus_rdata = patch_a[i][DW-1:0];
      end
      if (bus_addr == CTRL_ADDR) bus_rdata = {{(DW-CW){1'b0}}, ctrl_q};
    end
  end

  assign redirect        = |hit;
  assign redirect_target = hit[0] ? VEC_A : hit[1] ? VEC_B : '0;
endmodule

// File: rtl/patch_redirect_checker.sv
module patch_redirect_checker #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h0210,
  parameter logic [AW-1:0] VEC_A = 16'h02C0,
  parameter logic [AW-1:0] VEC_B = 16'h02E0,
  parameter logic [AW-1:0] EXEMPT_LO = 16'h1000,
  parameter logic [AW-1:0] EXEMPT_HI = 16'h1FFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_op,
  input logic          ext_rom_sel,
  input logic          redirect,
  input logic [AW-1:0] redirect_target,
  input logic [AW-1:0] a0,
  input logic [AW-1:0] a1,
  input logic [3:0]    en
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en == 4'd0 && a0 == '0 && a1 == '0));

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == CTRL_ADDR) |-> bus_rdata[DW-1:4] == '0);

  assert_entry_a_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redirect_target == VEC_A) |-> (fetch_addr == a0 && en[0]));

  assert_entry_b_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redirect_target == VEC_B) |-> (fetch_addr == a1 && en[1]));

  assert_idle_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> redirect_target == '0);

  assert_opcode_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetch_op);

  assert_exempt_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && ext_rom_sel) |-> (fetch_addr < EXEMPT_LO || fetch_addr > EXEMPT_HI));

  assert_entry_a_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redirect_target == VEC_B) |-> !(en[0] && fetch_addr == a0));
endmodule

bind patch_redirect patch_redirect_checker #(
  .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .VEC_A(VEC_A), .VEC_B(VEC_B),
  .EXEMPT_LO(EXEMPT_LO), .EXEMPT_HI(EXEMPT_HI)
) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .fetch_addr(fetch_addr), .fetch_op(fetch_op),
  .ext_rom_sel(ext_rom_sel), .redirect(redirect),
  .redirect_target(redirect_target), .a0(patch_a[0]), .a1(patch_a[1]),
  .en(ctrl_q)
);

// File: tb/patch_redirect_test.sv
`timescale 1ns/1ps
module patch_redirect_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] fetch_addr = '0;
  logic        fetch_op = 0, ext_rom_sel = 0;
  logic        redirect;
  logic [15:0] redirect_target;

  int checks = 0, errors = 0;

  typedef struct {
    bit          is_rd;
    bit          exp_redir;
    logic [15:0] exp_val;
    string       req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  patch_redirect uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .fetch_addr(fetch_addr), .fetch_op(fetch_op), .ext_rom_sel(ext_rom_sel),
    .redirect(redirect), .redirect_target(redirect_target)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.is_rd) begin
        if (bus_rdata !== it.exp_val[7:0]) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", it.req, bus_rdata, it.exp_val[7:0]);
        end
      end else if (redirect !== it.exp_redir || redirect_target !== it.exp_val) begin
        errors++;
        $display("FAIL %s: redirect/target actual %b/%h expected %b/%h",
                 it.req, redirect, redirect_target, it.exp_redir, it.exp_val);
      end
    end
  end

  task automatic step(bit we, bit re, bit op, bit sel, logic [15:0] ba,
                      logic [7:0] wd, logic [15:0] fa);
    @(posedge clk); #1;
    bus_we = we; bus_re = re; fetch_op = op; ext_rom_sel = sel;
    bus_addr = ba; bus_wdata = wd; fetch_addr = fa;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    step(1, 0, 0, 0, a, d, 16'h0);
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] e, string req);
    step(0, 1, 0, 0, a, 8'h0, 16'h0);
    q.push_back('{1'b1, 1'b0, {8'h0, e}, req});
  endtask

  task automatic fe(logic [15:0] fa, bit op, bit sel, bit er, logic [15:0] et, string req);
    step(0, 0, op, sel, 16'h0, 8'h0, fa);
    q.push_back('{1'b0, er, et, req});
  endtask

  task automatic set_entry(int n, logic [15:0] a);
    wr(16'h020C + 16'(2 * n), a[15:8]);
    wr(16'h020D + 16'(2 * n), a[7:0]);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(16'h020C, 8'h00, "R1"); rd(16'h020D, 8'h00, "R1");
    rd(16'h020E, 8'h00, "R1"); rd(16'h020F, 8'h00, "R1");
    rd(16'h0210, 8'h00, "R1");
    fe(16'h0000, 1, 0, 0, 16'h0000, "R1");
    // R2 register readback
    wr(16'h020C, 8'h12); wr(16'h020D, 8'h34);
    wr(16'h020E, 8'h56); wr(16'h020F, 8'h78);
    rd(16'h020C, 8'h12, "R2"); rd(16'h020D, 8'h34, "R2");
    rd(16'h020E, 8'h56, "R2"); rd(16'h020F, 8'h78, "R2");
    // R3 control register
    wr(16'h0210, 8'hFF); rd(16'h0210, 8'h0F, "R3");
    wr(16'h0210, 8'h0C); rd(16'h0210, 8'h0C, "R3");
    // R7 disabled entries
    fe(16'h1234, 1, 0, 0, 16'h0000, "R7");
    fe(16'h5678, 1, 0, 0, 16'h0000, "R7");
    // R4 unmapped
    rd(16'h0211, 8'h00, "R4"); rd(16'h020B, 8'h00, "R4"); rd(16'h0000, 8'h00, "R4");
    // R5 redirects
    wr(16'h0210, 8'h01);
    fe(16'h1234, 1, 0, 1, 16'h02C0, "R5");
    fe(16'h5678, 1, 0, 0, 16'h0000, "R7");
    wr(16'h0210, 8'h03);
    fe(16'h5678, 1, 0, 1, 16'h02E0, "R5");
    fe(16'h9999, 1, 0, 0, 16'h0000, "R5");
    // R6 operand fetch
    fe(16'h1234, 0, 0, 0, 16'h0000, "R6");
    fe(16'h5678, 0, 0, 0, 16'h0000, "R6");
    // R10 write timing: write and fetch in the same cycle
    step(1, 0, 1, 0, 16'h020D, 8'h35, 16'h1234);
    q.push_back('{1'b0, 1'b1, 16'h02C0, "R10"});
    fe(16'h1235, 1, 0, 1, 16'h02C0, "R10");
    fe(16'h1234, 1, 0, 0, 16'h0000, "R10");
    // R8 expansion window
    set_entry(0, 16'h1800);
    fe(16'h1800, 1, 1, 0, 16'h0000, "R8");
    fe(16'h1800, 1, 0, 1, 16'h02C0, "R8");
    set_entry(1, 16'h2000);
    fe(16'h2000, 1, 1, 1, 16'h02E0, "R8");
    set_entry(1, 16'h1FFF);
    fe(16'h1FFF, 1, 1, 0, 16'h0000, "R8");
    set_entry(1, 16'h1000);
    fe(16'h1000, 1, 1, 0, 16'h0000, "R8");
    fe(16'h1000, 1, 0, 1, 16'h02E0, "R8");
    set_entry(1, 16'h0FFF);
    fe(16'h0FFF, 1, 1, 1, 16'h02E0, "R8");
    // R9 priority
    set_entry(0, 16'h4000); set_entry(1, 16'h4000);
    fe(16'h4000, 1, 0, 1, 16'h02C0, "R9");
    wr(16'h0210, 8'h02);
    fe(16'h4000, 1, 0, 1, 16'h02E0, "R9");
    step(0, 0, 0, 0, 16'h0, 8'h0, 16'h0);
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule